// File: doc/BRIEF.md
# Oscillator Enable Handshake Controller

This block sits between a software-visible enable bit and an on-chip oscillator. Software writes the bit to ask for the oscillator to run or to stop. The bit software reads back follows the real condition of the oscillator, not the value that was written. It reads one only once the oscillator has started. It reads zero only once the oscillator has fully stopped. The controller drives the oscillator enable and gives a clock-valid flag that downstream clock selection must see high before it uses the oscillator as a source.

Each start and stop needs two things: a minimum number of cycles, set by a parameter, and a level acknowledge from the oscillator (high when running, low when stopped). A sleep request from the power manager forces the oscillator off. A hidden software-intent bit remembers whether software still wants the oscillator. When sleep ends, the oscillator restarts only if that bit is still set. If software asks for a restart while a stop is still in progress, the request is dropped and flagged.

The states are OFF, STARTING, ON and STOPPING. These are the transitions:
- OFF to STARTING: enable requested and no sleep.
- STARTING to ON: start time elapsed and acknowledge high.
- STARTING to STOPPING: abort or sleep.
- ON to STOPPING: disable or sleep.
- STOPPING to OFF: stop time elapsed and acknowledge low.

Top module: `osc_enable_ctrl`

## Requirements
- R1: After reset the controller is OFF: `osc_en`, `en_rd`, `clk_valid` and `req_err` are all 0.
- R2: A write of 1 (`wr_en`=1, `wr_data`=1) in OFF with `sleep_req` low raises `osc_en` at the next clock edge (STARTING). `en_rd` stays 0 for the whole of STARTING.
- R3: STARTING moves to ON only after at least START_CYCLES cycles in STARTING and with `osc_ack` high at that edge. `en_rd` and `clk_valid` rise at the same edge.
- R4: A write of 0 in ON drops `osc_en` and `clk_valid` at the next edge (STOPPING) while `en_rd` stays 1. `en_rd` falls (OFF) only after at least STOP_CYCLES cycles in STOPPING and with `osc_ack` low at that edge.
- R5: A write of 1 in STOPPING is ignored: the state and the software intent stay as they were. `req_err` is high in that same cycle and in no other cycle.
- R6: `clk_valid` is high exactly in ON, which is the only state where `osc_en` and `en_rd` are both 1.
- R7: `sleep_req` high moves STARTING or ON to STOPPING at the next edge. While `sleep_req` is high, OFF never moves to STARTING, even on a write of 1.
- R8: When `sleep_req` is low in OFF, the oscillator restarts if the last accepted write was 1, including a write of 1 made during sleep. After a write of 0 it stays off.
- R9: A write of 0 in STARTING aborts the start: it moves to STOPPING at the next edge without ever reaching ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the enable bit |
| wr_data | input | 1 | Written enable value |
| sleep_req | input | 1 | Sleep mode active: force oscillator off |
| osc_ack | input | 1 | Oscillator running level (1 = running, 0 = stopped) |
| osc_en | output | 1 | Oscillator enable |
| en_rd | output | 1 | Read-back value of the enable bit |
| clk_valid | output | 1 | Oscillator usable as a clock source |
| req_err | output | 1 | Pulse: illegal enable request during STOPPING |

## Verification
The bench aims at these corner cases:
- An acknowledge that arrives early or late. A design that trusted the timer alone or the acknowledge alone would report running too soon.
- A restart request during STOPPING. A design that got this wrong would re-enable the oscillator mid-stop, or fail to flag the request.
- An abort during STARTING. A design that got this wrong would still pass through ON.
- Sleep entry and exit with software intent set and cleared, including a write of 1 during sleep. A design that got this wrong would either fail to wake the oscillator or start it while asleep.
Random writes, sleep toggling and a jittery acknowledge are compared every cycle against a reference model of the state and intent.

// File: rtl/osc_hs_pkg.sv
package osc_hs_pkg;
    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_STARTING = 2'd1,
        ST_ON       = 2'd2,
        ST_STOPPING = 2'd3
    } osc_state_e;
endpackage

// File: rtl/osc_hs_timer.sv
// Dwell counter: counts cycles spent in the current state, saturating once
// the selected limit is reached.
module osc_hs_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt >= (limit - W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/osc_hs_fsm.sv
module osc_hs_fsm
    import osc_hs_pkg::*;
#(
    parameter int W = 4,
    parameter int START_CYCLES = 16,
    parameter int STOP_CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_data,
    input  logic         sleep_req,
    input  logic         osc_ack,
    input  logic         tmr_done,
    output logic         tmr_clear,
    output logic [W-1:0] tmr_limit,
    output logic         osc_en,
    output logic         en_rd,
    output logic         clk_valid,
    output logic         req_err
);
    osc_state_e state, state_n;
    logic       sw_want, sw_want_n;

    // Next-state and software-intent logic
    always_comb begin
        state_n   = state;
        sw_want_n = sw_want;
        unique case (state)
            ST_OFF: begin
                if (wr_en) sw_want_n = wr_data;
                if (!sleep_req && (wr_en ? wr_data : sw_want))
                    state_n = ST_STARTING;
            end
            ST_STARTING: begin
                if (wr_en) sw_want_n = wr_data;
                if (sleep_req || (wr_en && !wr_data))
                    state_n = ST_STOPPING;
                else if (tmr_done && osc_ack)
                    state_n = ST_ON;
            end
            ST_ON: begin
                if (wr_en) sw_want_n = wr_data;
                if (sleep_req || (wr_en && !wr_data))
                    state_n = ST_STOPPING;
            end
            ST_STOPPING: begin
                if (wr_en && !wr_data) sw_want_n = 1'b0;
                if (tmr_done && !osc_ack)
                    state_n = ST_OFF;
            end
            default: state_n = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            sw_want <= 1'b0;
        end else begin
            state   <= state_n;
            sw_want <= sw_want_n;
        end
    end

    // Outputs
    always_comb begin
        tmr_clear = (state_n != state);
        tmr_limit = (state == ST_STARTING) ? W'(START_CYCLES) : W'(STOP_CYCLES);
        osc_en    = 1'b0;
        en_rd     = 1'b0;
        clk_valid = 1'b0;
        req_err   = 1'b0;
        unique case (state)
            ST_OFF: ;
            ST_STARTING: osc_en = 1'b1;
            ST_ON: begin
                osc_en    = 1'b1;
                en_rd     = 1'b1;
                clk_valid = 1'b1;
            end
            ST_STOPPING: begin
                en_rd   = 1'b1;
                req_err = wr_en && wr_data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/osc_enable_ctrl.sv
module osc_enable_ctrl #(
    parameter int START_CYCLES = 16,
    parameter int STOP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    input  logic sleep_req,
    input  logic osc_ack,
    output logic osc_en,
    output logic en_rd,
    output logic clk_valid,
    output logic req_err
);
    localparam int MAX_CYC = (START_CYCLES > STOP_CYCLES) ? START_CYCLES : STOP_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             tmr_clear;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_limit;

    osc_hs_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    osc_hs_fsm #(
        .W            (CNT_W),
        .START_CYCLES (START_CYCLES),
        .STOP_CYCLES  (STOP_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sleep_req (sleep_req),
        .osc_ack   (osc_ack),
        .tmr_done  (tmr_done),
        .tmr_clear (tmr_clear),
        .tmr_limit (tmr_limit),
        .osc_en    (osc_en),
        .en_rd     (en_rd),
        .clk_valid (clk_valid),
        .req_err   (req_err)
    );
endmodule

// File: rtl/osc_enable_ctrl_chk.sv
module osc_enable_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_data,
    input logic sleep_req,
    input logic osc_ack,
    input logic osc_en,
    input logic en_rd,
    input logic clk_valid,
    input logic req_err
);
    assert_start_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> !en_rd);

    assert_on_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_valid) |-> $past(osc_ack) && en_rd);

    assert_off_needs_ack_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_rd) |-> !$past(osc_ack) && !osc_en);

    assert_err_only_stopping_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> en_rd && !osc_en && wr_en && wr_data);

    assert_valid_only_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_valid |-> en_rd && osc_en);

    assert_sleep_drops_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !clk_valid);

    assert_sleep_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !osc_en) |=> !osc_en);
endmodule

bind osc_enable_ctrl osc_enable_ctrl_chk u_chk (.*);

// File: tb/tb_osc_enable_ctrl.sv
`timescale 1ns/1ps
module tb_osc_enable_ctrl;
    localparam int SC = 4;
    localparam int PC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_data = 1'b0, sleep_req = 1'b0, osc_ack = 1'b0;
    logic osc_en, en_rd, clk_valid, req_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model: 0 OFF, 1 STARTING, 2 ON, 3 STOPPING
    int ms = 0;
    int mc = 0;
    bit mw = 1'b0;

    always #4 clk = ~clk;

    osc_enable_ctrl #(.START_CYCLES(SC), .STOP_CYCLES(PC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sleep_req(sleep_req), .osc_ack(osc_ack), .osc_en(osc_en),
        .en_rd(en_rd), .clk_valid(clk_valid), .req_err(req_err)
    );

    function automatic bit exp_osc(); return (ms == 1) || (ms == 2); endfunction
    function automatic bit exp_rd();  return (ms == 2) || (ms == 3); endfunction
    function automatic bit exp_cv();  return ms == 2; endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (model state %0d)", tag, what, act, exp, ms);
        end
    endtask

    task automatic check_outs(input string tag);
        check(tag, "osc_en", osc_en, exp_osc());
        check(tag, "en_rd", en_rd, exp_rd());
        check(tag, "clk_valid", clk_valid, exp_cv());
    endtask

    task automatic model_step(input bit we, input bit wd, input bit sl, input bit ak);
        int nx;
        nx = ms;
        case (ms)
            0: if (!sl && (we ? wd : mw)) nx = 1;
            1: if (sl || (we && !wd)) nx = 3;
               else if (mc >= SC - 1 && ak) nx = 2;
            2: if (sl || (we && !wd)) nx = 3;
            default: if (mc >= PC - 1 && !ak) nx = 0;
        endcase
        if (we && (ms != 3 || !wd)) mw = wd;
        mc = (nx != ms) ? 0 : mc + 1;
        ms = nx;
    endtask

    // called at a negedge: drive, check err, cross one edge, check outputs
    task automatic cycle(input bit we, input bit wd, input bit sl, input bit ak, input string tag);
        wr_en = we; wr_data = wd; sleep_req = sl; osc_ack = ak;
        #1;
        check(tag, "req_err", req_err, (ms == 3) && we && wd);
        @(posedge clk);
        model_step(we, wd, sl, ak);
        @(negedge clk);
        check_outs(tag);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_outs("R1");
        check("R1", "req_err", req_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: start with acknowledge withheld, stays STARTING reading zero
        cycle(1, 1, 0, 0, "R2");
        repeat (6) cycle(0, 0, 0, 0, "R2");
        // R3: acknowledge arrives late, then ON
        repeat (2) cycle(0, 0, 0, 1, "R3");
        // R4: disable, acknowledge stays high so stop is held
        cycle(1, 0, 0, 1, "R4");
        repeat (5) cycle(0, 0, 0, 1, "R4");
        repeat (3) cycle(0, 0, 0, 0, "R4");

        // R3: early acknowledge must still wait the start time
        cycle(1, 1, 0, 1, "R3");
        repeat (SC + 1) cycle(0, 0, 0, 1, "R3");
        // R5: restart request during STOPPING is ignored and flagged
        cycle(1, 0, 0, 1, "R5");
        cycle(1, 1, 0, 1, "R5");
        repeat (PC + 3) cycle(0, 0, 0, 0, "R5");

        // R9: abort during STARTING
        cycle(1, 1, 0, 0, "R9");
        cycle(0, 0, 0, 1, "R9");
        cycle(1, 0, 0, 1, "R9");
        repeat (PC + 2) cycle(0, 0, 0, 0, "R9");

        // R7/R8: sleep while ON, wake restarts with intent still set
        cycle(1, 1, 0, 1, "R8");
        repeat (SC + 1) cycle(0, 0, 0, 1, "R8");
        cycle(0, 0, 1, 1, "R7");
        repeat (PC + 2) cycle(0, 0, 1, 0, "R7");
        cycle(1, 1, 1, 0, "R7");
        repeat (2) cycle(0, 0, 1, 0, "R7");
        repeat (SC + 2) cycle(0, 0, 0, 1, "R8");
        // sleep, software disables while asleep: stays off after wake
        cycle(0, 0, 1, 1, "R7");
        cycle(1, 0, 1, 1, "R8");
        repeat (PC + 2) cycle(0, 0, 1, 0, "R8");
        repeat (4) cycle(0, 0, 0, 0, "R8");

        // R6: random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit we, wd, sl, ak;
            we = ($urandom % 5) == 0;
            wd = $urandom % 2;
            sl = ($urandom % 30 == 0) ? ~sleep_req : sleep_req;
            ak = ($urandom % 6 == 0) ? ~exp_osc() : exp_osc();
            cycle(we, wd, sl, ak, "R6");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule